// File: doc/BRIEF.md
# Framed Serial Command Port for a Segment Display Controller

This block is the host-facing serial port of a segment display and keypad controller. A host frames each transfer with a chip-enable line and clocks bits on a serial clock. While chip-enable is low, the host shifts in an 8-bit address, least significant bit first. Chip-enable then goes high and the host clocks the payload. A write carries one of three 42-bit display banks, a 4-bit zero filler, eight control bits and a 2-bit bank index. A read shifts out thirty key bits and then a sleep-acknowledge bit. Registers commit only when chip-enable falls. A frame with a bad address, a wrong length, a non-zero filler or an illegal bank index is dropped whole.

All three port inputs are treated as asynchronous. They are resynchronised to the system clock, and only rising serial-clock edges count, so the host may park the serial clock either low or high. The single open-drain output does two jobs. While chip-enable is low it reflects the key scanner's read request. During a read it carries the data bits. At all other times it is released. A one-cycle strobe tells the key scanner that its data has been read.

Top module: `cmdif_serial_port`

## Requirements
- R1: After a synchronous reset (rst_n low), disp_bits, all control outputs and sleep are 0, so_pull_low is 0 (pin released) and rd_done is 0.
- R2: Address 0x42, sent LSB first while ce is low, opens a write frame. The k-th payload bit sent (k from 0) lands in shift position k. With index 00, positions 0..41 load disp_bits[41:0], with the first payload bit in disp_bits[0].
- R3: The bank index is formed as {position 54, position 55}. Index 01 loads disp_bits[83:42] and index 10 loads disp_bits[125:84]. Other banks keep their values, and the control outputs change only for index 00.
- R4: With index 00, payload positions 46..53 load, in order: slp_sel[0], slp_sel[1], key_sel[0], key_sel[1], port_sel[0], port_sel[1], seg_on, bias_3rd.
- R5: A write frame with an address other than 0x42/0x43, a payload length other than 56 rising edges, non-zero filler (positions 42..45), or index 11 changes no output register.
- R6: No display or control output changes while ce is still high. The update becomes visible only after ce falls.
- R7: Address 0x43 opens a read frame. Before the first rising serial-clock edge, and after each one, the pin carries the next bit in the sequence key_bits[0]..key_bits[29] and then sleep. A 0 bit is the pin pulled low (so_pull_low=1). Key bits are captured when ce rises.
- R8: While ce is high in a write frame, and after a read frame has shifted out all 31 bits, so_pull_low is 0.
- R9: While ce is low, so_pull_low follows key_req.
- R10: rd_done pulses for exactly one clock after ce falls on a read frame that saw at least 30 rising serial-clock edges. It does not pulse for a shorter read or for a write.
- R11: Frames work identically whether sck idles low or high between bits.
- R12: sleep is 1 exactly when slp_sel is non-zero. It is cleared by an accepted index-00 write with both sleep bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Frame enable from host (asynchronous) |
| sck | input | 1 | Serial clock from host (asynchronous) |
| si | input | 1 | Serial data from host (asynchronous) |
| key_bits | input | 30 | Debounced key data from scanner |
| key_req | input | 1 | Scanner's key-data read request |
| so_pull_low | output | 1 | Drive for open-drain pin, 1 pulls low |
| disp_bits | output | 126 | Display register, three 42-bit banks |
| slp_sel | output | 2 | Sleep selection bits |
| key_sel | output | 2 | Key-scan/segment pin selection |
| port_sel | output | 2 | Segment/general-output selection |
| seg_on | output | 1 | Segment enable |
| bias_3rd | output | 1 | Bias selection (1 = one-third) |
| sleep | output | 1 | Sleep state |
| rd_done | output | 1 | One-cycle read-complete strobe to scanner |

## Verification
The hardest situation to reach is a read frame where each serial bit must be observed at the pin in the narrow window between one rising edge and the next, under both clock idle polarities. The bench handles this by driving the serial clock itself and sampling the pin half a bit period after each edge, just before the next rise. It computes the expected bit from the key pattern it captured at frame start. Malformed frames (55 and 57 bits, an index of 11, a stray address, non-zero filler) are built directly. They are mixed into a seeded random sequence of valid writes and reads, so that each rejection is checked against a register state that is not trivially zero.

// File: rtl/cmdif_pkg.sv
// Shared types for the framed serial command port.
// Assumes: eight control bits in a fixed transmission order.
package cmdif_pkg;
    typedef enum logic [1:0] {
        FR_NONE  = 2'd0,
        FR_WRITE = 2'd1,
        FR_READ  = 2'd2
    } frame_e;

    // Declared MSB first, so a cast of payload positions 53..46 lands in order.
    typedef struct packed {
        logic bias_3rd;
        logic seg_on;
        logic port1;
        logic port0;
        logic key1;
        logic key0;
        logic slp1;
        logic slp0;
    } ctl_t;
endpackage

// File: rtl/cmdif_sync.sv
// Two-flop synchroniser with edge detection for a group of asynchronous inputs.
// Assumes: inputs change no faster than a few system clocks.
module cmdif_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] m_q, s_q, d_q;

    // Resynchronise and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
            s_q <= '0;
            d_q <= '0;
        end else begin
            m_q <= async_in;
            s_q <= m_q;
            d_q <= s_q;
        end
    end

    assign lvl  = s_q;
    assign rise = s_q & ~d_q;
    assign fall = ~s_q & d_q;
endmodule

// File: rtl/cmdif_deser.sv
// Frame decoder: collects the address while ce is low, classifies the frame on ce rise,
// counts and shifts payload bits while ce is high, and raises commit/read-done on ce fall.
// Assumes: synchronised, edge-detected inputs; sck and ce edges are never simultaneous.
module cmdif_deser
    import cmdif_pkg::*;
#(
    parameter int          FRAME_W = 56,
    parameter int          ADDR_W  = 8,
    parameter int          NKEY    = 30,
    parameter logic [7:0]  WR_ADDR = 8'h42,
    parameter logic [7:0]  RD_ADDR = 8'h43,
    parameter int          CNT_W   = $clog2(FRAME_W) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce,
    input  logic               ce_rise,
    input  logic               ce_fall,
    input  logic               sck_rise,
    input  logic               si,
    output frame_e             kind,
    output logic [CNT_W-1:0]   bit_cnt,
    output logic [FRAME_W-1:0] word,
    output logic               commit,
    output logic               rd_done
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] KEY_CNT  = CNT_W'(NKEY);

    logic [ADDR_W-1:0] addr_sr;

    // Address shift register: LSB first, cleared at each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || ce_fall)     addr_sr <= '0;
        else if (!ce && sck_rise)  addr_sr <= {si, addr_sr[ADDR_W-1:1]};
    end

    // Frame classification, fixed for the whole high phase of ce.
    always_ff @(posedge clk) begin
        if (!rst_n || ce_fall)          kind <= FR_NONE;
        else if (ce_rise) begin
            if (addr_sr == WR_ADDR[ADDR_W-1:0])      kind <= FR_WRITE;
            else if (addr_sr == RD_ADDR[ADDR_W-1:0]) kind <= FR_READ;
            else                                     kind <= FR_NONE;
        end
    end

    // Saturating payload bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || ce_rise)                         bit_cnt <= '0;
        else if (ce && sck_rise && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end

    // Payload shift register: the k-th bit sent ends up at position k after a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 word <= '0;
        else if (ce && sck_rise && kind == FR_WRITE) word <= {si, word[FRAME_W-1:1]};
    end

    // End-of-frame strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit  <= 1'b0;
            rd_done <= 1'b0;
        end else begin
            commit  <= ce_fall && kind == FR_WRITE && bit_cnt == FULL_CNT;
            rd_done <= ce_fall && kind == FR_READ && bit_cnt >= KEY_CNT;
        end
    end

    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !ce_rise && bit_cnt == CNT_MAX) |=> bit_cnt == CNT_MAX);
    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);
endmodule

// File: rtl/cmdif_store.sv
// Display bank and control register store; commits a decoded write frame.
// Assumes: word is stable whenever commit is high (ce already low).
module cmdif_store
    import cmdif_pkg::*;
#(
    parameter int BANK_W  = 42,
    parameter int NBANK   = 3,
    parameter int PAD_W   = 4,
    parameter int IDX_W   = 2,
    parameter int FRAME_W = 56
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [FRAME_W-1:0]      word,
    output logic [NBANK*BANK_W-1:0] disp,
    output ctl_t                    ctl
);
    localparam int CTL_W   = $bits(ctl_t);
    localparam int CTL_LSB = BANK_W + PAD_W;
    localparam int IDX_LSB = CTL_LSB + CTL_W;

    logic [IDX_W-1:0]  idx;
    logic              pad_ok;
    logic              accept;
    logic [NBANK-1:0]  bank_we;
    logic [BANK_W-1:0] bank_q [NBANK];

    // The first index bit sent is the more significant one.
    always_comb begin
        for (int i = 0; i < IDX_W; i++) idx[IDX_W-1-i] = word[IDX_LSB + i];
    end
    assign pad_ok = (word[BANK_W +: PAD_W] == '0);
    assign accept = commit && pad_ok;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_we[b] = accept && (idx == IDX_W'(b));
        // One display bank, loaded only by its own index.
        always_ff @(posedge clk) begin
            if (!rst_n)          bank_q[b] <= '0;
            else if (bank_we[b]) bank_q[b] <= word[BANK_W-1:0];
        end
        assign disp[b*BANK_W +: BANK_W] = bank_q[b];
    end

    // Control register, loaded only by the first bank's frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          ctl <= '0;
        else if (bank_we[0]) ctl <= ctl_t'(word[CTL_LSB +: CTL_W]);
    end

    // R6
    disp_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp) |-> $past(commit));
    // R3
    ctl_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl) |-> $past(commit) && $stable(disp[NBANK*BANK_W-1:BANK_W]));
endmodule

// File: rtl/cmdif_serial_port.sv
// Top of the framed serial command port: synchronises host pins, decodes frames,
// stores display/control data and drives the shared open-drain output.
// Assumes: host holds each serial level for several system clocks.
module cmdif_serial_port
    import cmdif_pkg::*;
#(
    parameter int BANK_W = 42,
    parameter int NBANK  = 3,
    parameter int NKEY   = 30,
    parameter int PAD_W  = 4,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce,
    input  logic                    sck,
    input  logic                    si,
    input  logic [NKEY-1:0]         key_bits,
    input  logic                    key_req,
    output logic                    so_pull_low,
    output logic [NBANK*BANK_W-1:0] disp_bits,
    output logic [1:0]              slp_sel,
    output logic [1:0]              key_sel,
    output logic [1:0]              port_sel,
    output logic                    seg_on,
    output logic                    bias_3rd,
    output logic                    sleep,
    output logic                    rd_done
);
    localparam int FRAME_W = BANK_W + PAD_W + $bits(ctl_t) + IDX_W;
    localparam int CNT_W   = $clog2(FRAME_W) + 1;
    localparam int RD_W    = NKEY + 1;
    localparam int RD_IW   = $clog2(RD_W);

    logic [2:0]         s_lvl, s_rise, s_fall;
    frame_e             kind;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] word;
    logic               commit;
    ctl_t               ctl;
    logic [RD_W-1:0]    rd_sr;
    logic               rd_bit;

    cmdif_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in({si, sck, ce}),
        .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
    );

    cmdif_deser #(.FRAME_W(FRAME_W), .NKEY(NKEY), .CNT_W(CNT_W)) u_deser (
        .clk(clk), .rst_n(rst_n), .ce(s_lvl[0]), .ce_rise(s_rise[0]),
        .ce_fall(s_fall[0]), .sck_rise(s_rise[1]), .si(s_lvl[2]),
        .kind(kind), .bit_cnt(bit_cnt), .word(word), .commit(commit), .rd_done(rd_done)
    );

    cmdif_store #(.BANK_W(BANK_W), .NBANK(NBANK), .PAD_W(PAD_W), .IDX_W(IDX_W),
                  .FRAME_W(FRAME_W)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .word(word),
        .disp(disp_bits), .ctl(ctl)
    );

    assign slp_sel  = {ctl.slp1, ctl.slp0};
    assign key_sel  = {ctl.key1, ctl.key0};
    assign port_sel = {ctl.port1, ctl.port0};
    assign seg_on   = ctl.seg_on;
    assign bias_3rd = ctl.bias_3rd;
    assign sleep    = ctl.slp1 | ctl.slp0;

    // Read data snapshot: key bits then sleep acknowledge, taken at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_sr <= '0;
        else if (s_rise[0])  rd_sr <= {sleep, key_bits};
    end

    assign rd_bit = (bit_cnt < CNT_W'(RD_W)) ? rd_sr[bit_cnt[RD_IW-1:0]] : 1'b1;

    // Shared open-drain output: request flag when idle, data in a read, released otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)               so_pull_low <= 1'b0;
        else if (!s_lvl[0])       so_pull_low <= key_req;
        else if (kind == FR_READ) so_pull_low <= ~rd_bit;
        else                      so_pull_low <= 1'b0;
    end

    // R8
    so_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_lvl[0] && $past(s_lvl[0]) && $past(kind) == FR_WRITE) |-> !so_pull_low);
    // R12
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slp_sel == 2'b00) |-> !sleep);
endmodule

// File: tb/test_cmdif_serial_port.sv
module test_cmdif_serial_port;
    localparam int BANK_W = 42;
    localparam int NBANK  = 3;
    localparam int NKEY   = 30;
    localparam int DISP_W = BANK_W * NBANK;
    localparam int HALF   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0, sck = 1'b0, si = 1'b0;
    logic [NKEY-1:0] key_bits = '0;
    logic key_req = 1'b0;
    logic so_pull_low;
    logic [DISP_W-1:0] disp_bits;
    logic [1:0] slp_sel, key_sel, port_sel;
    logic seg_on, bias_3rd, sleep, rd_done;

    int n_chk = 0, n_fail = 0, n_rd = 0;
    logic [DISP_W-1:0] exp_disp = '0;
    logic [7:0] exp_ctl = '0;

    always #2.5 clk = ~clk;

    cmdif_serial_port i_cmdif_serial_port (
        .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .si(si),
        .key_bits(key_bits), .key_req(key_req), .so_pull_low(so_pull_low),
        .disp_bits(disp_bits), .slp_sel(slp_sel), .key_sel(key_sel),
        .port_sel(port_sel), .seg_on(seg_on), .bias_3rd(bias_3rd),
        .sleep(sleep), .rd_done(rd_done)
    );

    always @(negedge clk) if (rst_n && rd_done) n_rd++;

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] ctl_now();
        return {bias_3rd, seg_on, port_sel, key_sel, slp_sel};
    endfunction

    function automatic logic [63:0] mk_word(input logic [BANK_W-1:0] d, input logic [7:0] c,
                                            input logic [1:0] dd, input logic [3:0] pad);
        logic [63:0] w = '0;
        w[41:0] = d; w[45:42] = pad; w[53:46] = c; w[54] = dd[1]; w[55] = dd[0];
        return w;
    endfunction

    task automatic tx_bit(input logic b, input logic idle_hi);
        if (idle_hi) begin sck = 1'b0; si = b; wclk(HALF); sck = 1'b1; wclk(HALF); end
        else begin si = b; wclk(HALF); sck = 1'b1; wclk(HALF); sck = 1'b0; end
    endtask

    task automatic tx_addr(input logic [7:0] a, input logic idle_hi);
        sck = idle_hi; wclk(4);
        for (int i = 0; i < 8; i++) tx_bit(a[i], idle_hi);
        wclk(HALF); ce = 1'b1; wclk(HALF);
    endtask

    task automatic do_write(input string tag, input logic [7:0] a, input logic [63:0] w,
                            input int nb, input logic idle_hi);
        logic ok;
        tx_addr(a, idle_hi);
        for (int i = 0; i < nb; i++) begin
            tx_bit(w[i], idle_hi);
            if (i == nb / 2) chk("R8 write-frame pin", {127'd0, so_pull_low}, 128'd0);
        end
        wclk(HALF);
        chk("R6 before ce fall", {2'd0, disp_bits}, {2'd0, exp_disp});
        chk("R6 ctl before ce fall", {120'd0, ctl_now()}, {120'd0, exp_ctl});
        ce = 1'b0; wclk(10);
        ok = (a == 8'h42) && (nb == 56) && (w[45:42] == 4'd0) && ({w[54], w[55]} != 2'b11);
        if (ok) begin
            case ({w[54], w[55]})
                2'b00: begin exp_disp[41:0] = w[41:0]; exp_ctl = w[53:46]; end
                2'b01: exp_disp[83:42] = w[41:0];
                default: exp_disp[125:84] = w[41:0];
            endcase
        end
        chk(tag, {2'd0, disp_bits}, {2'd0, exp_disp});
        chk({tag, " ctl R4"}, {120'd0, ctl_now()}, {120'd0, exp_ctl});
        chk("R12 sleep", {127'd0, sleep}, {127'd0, |exp_ctl[1:0]});
    endtask

    task automatic do_read(input int nb, input logic idle_hi, input logic [NKEY-1:0] keys);
        logic [NKEY:0] seq;
        int rd0;
        logic e;
        key_bits = keys;
        seq = {|exp_ctl[1:0], keys};
        rd0 = n_rd;
        tx_addr(8'h43, idle_hi);
        for (int i = 0; i < nb; i++) begin
            if (idle_hi) sck = 1'b0;
            wclk(HALF);
            e = (i <= NKEY) ? seq[i] : 1'b1;
            chk(idle_hi ? "R7 R11 read bit" : "R7 read bit", {127'd0, ~so_pull_low}, {127'd0, e});
            sck = 1'b1; wclk(HALF);
            if (!idle_hi) sck = 1'b0;
        end
        wclk(HALF);
        if (nb > NKEY) chk("R8 after read", {127'd0, so_pull_low}, 128'd0);
        ce = 1'b0; wclk(10);
        chk("R10 rd_done count", 128'(n_rd - rd0), (nb >= NKEY) ? 128'd1 : 128'd0);
    endtask

    initial begin
        int guard = 0;
        while (guard < 150000) begin @(posedge clk); guard++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] w;
        void'($urandom(32'd20511));
        wclk(5); rst_n = 1'b1; wclk(4);
        // R1 reset state
        chk("R1 disp", {2'd0, disp_bits}, 128'd0);
        chk("R1 ctl", {120'd0, ctl_now()}, 128'd0);
        chk("R1 pin", {125'd0, so_pull_low, sleep, rd_done}, 128'd0);

        // R2 R4 R12 bank 0 with sleep bit, sck idle low
        w = mk_word(42'h2A5_1234_5678, 8'b1010_0101, 2'b00, 4'd0);
        do_write("R2 bank0", 8'h42, w, 56, 1'b0);
        // R3 R11 bank 1 with idle-high clock; control must stay
        w = mk_word(42'h3FF_0000_FFFF, 8'hFF, 2'b01, 4'd0);
        do_write("R3 R11 bank1", 8'h42, w, 56, 1'b1);
        w = mk_word(42'h155_5555_5555, 8'h00, 2'b10, 4'd0);
        do_write("R3 bank2", 8'h42, w, 56, 1'b0);

        // R5 rejected frames
        w = mk_word(42'h0FF, 8'h3C, 2'b00, 4'd0);
        do_write("R5 bad addr", 8'h44, w, 56, 1'b0);
        do_write("R5 short", 8'h42, w, 55, 1'b1);
        do_write("R5 long", 8'h42, w, 57, 1'b0);
        do_write("R5 filler", 8'h42, mk_word(42'h0FF, 8'h3C, 2'b00, 4'd2), 56, 1'b0);
        do_write("R5 index 11", 8'h42, mk_word(42'h0FF, 8'h3C, 2'b11, 4'd0), 56, 1'b1);

        // R9 request flag while ce low
        key_req = 1'b1; wclk(3);
        chk("R9 req high", {127'd0, so_pull_low}, 128'd1);
        key_req = 1'b0; wclk(3);
        chk("R9 req low", {127'd0, so_pull_low}, 128'd0);

        // R7 R10 R11 reads
        do_read(31, 1'b0, 30'h2AAA_5555);
        do_read(32, 1'b1, 30'h1234_5678);
        do_read(20, 1'b0, 30'h3FFF_0000);
        do_read(30, 1'b1, 30'h0F0F_0F0F);

        // R12 clear sleep
        do_write("R12 wake", 8'h42, mk_word(42'h1, 8'b1100_0000, 2'b00, 4'd0), 56, 1'b0);

        // Seeded random mix
        for (int it = 0; it < 24; it++) begin
            int op = $urandom_range(0, 9);
            logic [BANK_W-1:0] d = {$urandom(), $urandom()};
            logic [7:0] c = 8'($urandom());
            logic [1:0] dd = 2'($urandom_range(0, 2));
            logic ih = 1'($urandom());
            if (op < 6) do_write("R2 R3 random", 8'h42, mk_word(d, c, dd, 4'd0), 56, ih);
            else if (op < 8) do_read(31, ih, 30'($urandom()));
            else do_write("R5 random reject", 8'h42, mk_word(d, c, 2'b11, 4'd0), 56, ih);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule